// File: doc/BRIEF.md
# Camera Serial Link Power-Mode Controller

This block decides the operating mode of a camera serial transmitter. It runs on a free-running reference clock. From five inputs it selects one of four modes: shut down, standby, acquiring, or transmitting. The inputs are an enable pin, the camera pixel clock, a PLL lock flag, the frame sync, and a line-counter mode select. The pixel clock itself is treated only as a signal. It is synchronized into the reference domain, and a window counter over its rising edges decides whether the clock counts as running. Two thresholds give that decision hysteresis.

The enable pin passes through a glitch filter. A new level is accepted only after it has been held for a set number of reference cycles. Out of reset, the filter takes the pin's level at once. Once the pixel clock is active, the controller turns the PLL on and keeps the line drivers in high impedance. It then waits for lock, followed by one frame start, or two frame starts when the line-counter mode is on. Only then does it enable the drivers and pulse the transmit-start output. All outputs are registered.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While reset is held, `mode_o` reads 0 (shut down) and `drv_en_o`, `pll_en_o` and `tx_go_o` are low. The mode encoding is 0 shut down, 1 standby, 2 acquiring, 3 transmitting.
- R2: After reset is released, the enable level is adopted after SYNC_STAGES+1 reference cycles, with no glitch-filter delay. With enable high and no pixel clock, `mode_o` becomes 1 within 8 cycles.
- R3: After power-up, a change on `en_i` takes effect only once the new level has been seen for FILT_CYC consecutive cycles. A shorter pulse leaves every output unchanged.
- R4: A filtered-low enable forces mode 0 from any mode, with drivers and PLL off. Pixel-clock activity has no effect while in mode 0.
- R5: With the enable filtered high and the pixel clock judged inactive, the mode is 1 and the drivers and PLL are off. Mode 0 always passes through mode 1 on the way up.
- R6: Over each window of WIN_CYC reference cycles, the rising pixel-clock edges are counted. An inactive clock becomes active at HI_THR or more edges. An active clock becomes inactive below LO_THR edges. Counts in between keep the previous decision.
- R7: In mode 2, `pll_en_o` is high and `drv_en_o` is low.
- R8: Frame-sync rising edges are counted in mode 2 only while lock is reported. FRAMES_PLAIN edges (with `lcnt_mode_i` low) or FRAMES_COUNTED edges (with it high) move the block to mode 3. On that move, `drv_en_o` and `pll_en_o` go high and `tx_go_o` pulses for exactly one cycle.
- R9: If the pixel clock becomes inactive in mode 2 or mode 3, the block returns to mode 1 with drivers and PLL off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmitter enable pin (asynchronous) |
| pix_clk_i | input | 1 | Camera pixel clock, sampled as data |
| pll_lock_i | input | 1 | PLL lock flag (asynchronous) |
| vs_i | input | 1 | Frame sync, active high (asynchronous) |
| lcnt_mode_i | input | 1 | Line-counter mode select: 1 waits for two frame starts |
| drv_en_o | output | 1 | Serial driver enable; 0 means high impedance |
| pll_en_o | output | 1 | PLL enable |
| tx_go_o | output | 1 | One-cycle pulse on entry into transmit |
| mode_o | output | 2 | Current operating mode |

## Verification
The embedded properties are checked on every cycle:
- a filtered-low enable lands in shut down on the next cycle;
- an inactive clock with enable high lands in standby;
- the activity decision changes only at a window boundary;
- the filter output moves only after a full hold count;
- transmit is entered only with lock present, and the start pulse lasts one cycle.

Some behaviours can only be shown by the bench scenarios. These are:
- that short enable pulses are really discarded;
- the hysteresis band, where a mid-rate clock holds either decision;
- the difference between one and two frame starts;
- that frame starts arriving before lock are not counted;
- that each mode change appears in the expected order.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;

    // Operating modes; the numeric values are visible on mode_o.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_ACQ  = 2'd2,
        ST_RUN  = 2'd3
    } lpc_state_e;

endpackage

// File: rtl/lpc_sync.sv
`timescale 1ns/1ps
module lpc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[0] <= '0;
                else         stg_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[s] <= '0;
                else         stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/lpc_en_filter.sv
`timescale 1ns/1ps
module lpc_en_filter #(
    parameter int FILT_CYC    = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_s_i,
    output logic en_f_o
);

    localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
    localparam int PW = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [PW-1:0] prime;
        logic          primed;
        logic [CW-1:0] cnt;
        logic          filt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (!flt_q.primed) begin
            // Wait until the synchronizer carries the real pin level, then take it unfiltered.
            if (flt_q.prime == PW'(SYNC_STAGES)) begin
                flt_d.primed = 1'b1;
                flt_d.filt   = en_s_i;
            end else begin
                flt_d.prime = flt_q.prime + 1'b1;
            end
        end else if (en_s_i == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_CYC - 1)) begin
            flt_d.filt = en_s_i;
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flt_q <= '0;
        else         flt_q <= flt_d;
    end

    assign en_f_o = flt_q.filt;

    // R3: after priming, the filtered level moves only at the end of a full hold count
    assert_filter_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(flt_q.primed) && !$stable(flt_q.filt)) |-> ($past(flt_q.cnt) == CW'(FILT_CYC - 1)));

endmodule

// File: rtl/lpc_clk_mon.sv
`timescale 1ns/1ps
module lpc_clk_mon #(
    parameter int WIN_CYC = 1000,
    parameter int HI_THR  = 8,
    parameter int LO_THR  = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic pix_s_i,
    output logic active_o
);

    localparam int WW = $clog2(WIN_CYC);
    localparam int EW = $clog2(WIN_CYC + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [EW-1:0] edges;
        logic          prev;
        logic          active;
    } mon_t;

    mon_t mon_d, mon_q;
    logic          rise;
    logic          win_end;
    logic [EW-1:0] tot;

    always_comb begin
        rise    = pix_s_i & ~mon_q.prev;
        tot     = mon_q.edges + EW'(rise);
        win_end = run_i && (mon_q.win == WW'(WIN_CYC - 1));
        mon_d   = mon_q;
        if (!run_i) begin
            mon_d      = '0;
            mon_d.prev = pix_s_i;
        end else begin
            mon_d.prev = pix_s_i;
            if (win_end) begin
                mon_d.win   = '0;
                mon_d.edges = '0;
                if (mon_q.active && (tot < EW'(LO_THR)))
                    mon_d.active = 1'b0;
                else if (!mon_q.active && (tot >= EW'(HI_THR)))
                    mon_d.active = 1'b1;
            end else begin
                mon_d.win   = mon_q.win + 1'b1;
                mon_d.edges = tot;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= '0;
        else         mon_q <= mon_d;
    end

    assign active_o = mon_q.active;

    // R6: the activity decision changes only at a window boundary or when the monitor is stopped
    assert_act_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mon_q.active) |-> ($past(win_end) || !$past(run_i)));

endmodule

// File: rtl/link_pwr_ctrl.sv
`timescale 1ns/1ps
module link_pwr_ctrl
    import lpc_pkg::*;
#(
    parameter int FILT_CYC       = 1250,
    parameter int WIN_CYC        = 1000,
    parameter int HI_THR         = 8,
    parameter int LO_THR         = 4,
    parameter int SYNC_STAGES    = 2,
    parameter int FRAMES_PLAIN   = 1,
    parameter int FRAMES_COUNTED = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       pix_clk_i,
    input  logic       pll_lock_i,
    input  logic       vs_i,
    input  logic       lcnt_mode_i,
    output logic       drv_en_o,
    output logic       pll_en_o,
    output logic       tx_go_o,
    output logic [1:0] mode_o
);

    localparam int FMAX = (FRAMES_COUNTED > FRAMES_PLAIN) ? FRAMES_COUNTED : FRAMES_PLAIN;
    localparam int FW   = $clog2(FMAX + 1);

    typedef struct packed {
        lpc_state_e    state;
        logic [FW-1:0] frames;
        logic          vs_prev;
        logic          drv;
        logic          pll;
        logic          go;
    } fsm_t;

    logic [4:0] raw, syn;
    logic en_s, pix_s, lock_s, vs_s, lcnt_s;
    logic en_f, clk_act;

    assign raw = {en_i, pix_clk_i, pll_lock_i, vs_i, lcnt_mode_i};
    assign {en_s, pix_s, lock_s, vs_s, lcnt_s} = syn;

    lpc_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw),
        .q_o   (syn)
    );

    lpc_en_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_s_i(en_s),
        .en_f_o(en_f)
    );

    lpc_clk_mon #(.WIN_CYC(WIN_CYC), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_mon (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (en_f),
        .pix_s_i (pix_s),
        .active_o(clk_act)
    );

    fsm_t          fsm_d, fsm_q;
    logic          vs_rise;
    logic [FW-1:0] need;

    always_comb begin
        fsm_d         = fsm_q;
        vs_rise       = vs_s & ~fsm_q.vs_prev;
        need          = lcnt_s ? FW'(FRAMES_COUNTED) : FW'(FRAMES_PLAIN);
        fsm_d.vs_prev = vs_s;
        if (!en_f) begin
            fsm_d.state  = ST_OFF;
            fsm_d.frames = '0;
        end else begin
            unique case (fsm_q.state)
                ST_OFF: fsm_d.state = ST_IDLE;
                ST_IDLE: begin
                    if (clk_act) begin
                        fsm_d.state  = ST_ACQ;
                        fsm_d.frames = '0;
                    end
                end
                ST_ACQ: begin
                    if (!clk_act) begin
                        fsm_d.state = ST_IDLE;
                    end else if (!lock_s) begin
                        fsm_d.frames = '0;
                    end else if (vs_rise) begin
                        if ((fsm_q.frames + 1'b1) >= need) fsm_d.state = ST_RUN;
                        else                               fsm_d.frames = fsm_q.frames + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!clk_act) fsm_d.state = ST_IDLE;
                end
                default: fsm_d.state = ST_OFF;
            endcase
        end
        fsm_d.pll = (fsm_d.state == ST_ACQ) || (fsm_d.state == ST_RUN);
        fsm_d.drv = (fsm_d.state == ST_RUN);
        fsm_d.go  = (fsm_d.state == ST_RUN) && (fsm_q.state != ST_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= '0;
        else         fsm_q <= fsm_d;
    end

    assign mode_o   = fsm_q.state;
    assign drv_en_o = fsm_q.drv;
    assign pll_en_o = fsm_q.pll;
    assign tx_go_o  = fsm_q.go;

    // R4: a filtered-low enable lands in shut down with everything off
    assert_shutdown_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_f |=> (mode_o == 2'd0 && !drv_en_o && !pll_en_o && !tx_go_o));

    // R5 / R9: enable high with an inactive clock lands in standby
    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_f && !clk_act) |=> (mode_o == 2'd1 && !drv_en_o && !pll_en_o));

    // R8: transmit starts only with lock present
    assert_lock_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_go_o) |-> $past(lock_s));

    // R8: the start pulse lasts a single cycle
    assert_go_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_go_o |=> !tx_go_o);

endmodule

// File: tb/link_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb;

    localparam logic [3:0] V_OFF  = 4'b0000;  // {mode, drv, pll}
    localparam logic [3:0] V_IDLE = 4'b0100;
    localparam logic [3:0] V_ACQ  = 4'b1001;
    localparam logic [3:0] V_RUN  = 4'b1111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, pix = 1'b0, lock = 1'b0, vs = 1'b0, lcm = 1'b0;
    logic drv, pll, go;
    logic [1:0] mode;
    int pix_half = 0;

    always #4 clk = ~clk;

    always begin
        if (pix_half == 0) begin
            pix = 1'b0;
            #8;
        end else begin
            #(pix_half) pix = ~pix;
        end
    end

    link_pwr_ctrl #(
        .FILT_CYC(20), .WIN_CYC(32), .HI_THR(5), .LO_THR(2),
        .SYNC_STAGES(2), .FRAMES_PLAIN(1), .FRAMES_COUNTED(2)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pix_clk_i(pix),
        .pll_lock_i(lock), .vs_i(vs), .lcnt_mode_i(lcm),
        .drv_en_o(drv), .pll_en_o(pll), .tx_go_o(go), .mode_o(mode)
    );

    wire [3:0] obs = {mode, drv, pll};

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] last_obs = 4'b0000;
    logic [3:0] exp_v;
    string      exp_t;
    int n_chk = 0, n_bad = 0, go_seen = 0;
    bit done = 1'b0;

    // Monitor: every output change pops the next expected item.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (go) go_seen++;
            if (obs !== last_obs) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected change: outputs %b expected %b", obs, last_obs);
                end else begin
                    exp_v = exp_q.pop_front();
                    exp_t = tag_q.pop_front();
                    if (obs !== exp_v) begin
                        n_bad++;
                        $display("FAIL %s: outputs %b expected %b", exp_t, obs, exp_v);
                    end
                end
                last_obs = obs;
            end
        end
    end

    task automatic push(input logic [3:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_now(input logic [3:0] v, input string t);
        n_chk++;
        if (obs !== v) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", t, obs, v);
        end
    endtask

    task automatic drained(input string t);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d changes missing, outputs %b expected %b", t, exp_q.size(), obs, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic check_go(input int n, input string t);
        n_chk++;
        if (go_seen != n) begin
            n_bad++;
            $display("FAIL %s: start pulses %0d expected %0d", t, go_seen, n);
        end
    endtask

    task automatic vs_pulse();
        vs = 1'b1;
        cycles(4);
        vs = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run still busy, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check_now(V_OFF, "R1");                       // R1 reset state
        n_chk++;
        if (go !== 1'b0) begin n_bad++; $display("FAIL R1: go %b expected 0", go); end
        push(V_IDLE, "R2");
        rst_n = 1'b1;
        cycles(8);
        drained("R2");                                // R2 enable taken without filter delay
        check_now(V_IDLE, "R5");

        en = 1'b0; cycles(10); en = 1'b1;             // R3 short pulse ignored
        cycles(30);
        check_now(V_IDLE, "R3");

        pix_half = 20;                                // R6 fast clock becomes active
        push(V_ACQ, "R6");
        cycles(120);
        drained("R6");
        check_now(V_ACQ, "R7");                       // R7 PLL on, drivers off

        vs_pulse(); cycles(10);                       // R8 frame start before lock not counted
        check_now(V_ACQ, "R8");
        lock = 1'b1; cycles(5);
        push(V_RUN, "R8");
        vs_pulse(); cycles(10);
        drained("R8");
        check_go(1, "R8");

        pix_half = 40; cycles(150);                   // R6 mid band keeps active
        check_now(V_RUN, "R6");

        pix_half = 0;                                 // R9 clock loss in transmit
        push(V_IDLE, "R9");
        cycles(120);
        drained("R9");

        pix_half = 40; cycles(150);                   // R6 mid band keeps inactive
        check_now(V_IDLE, "R6");

        push(V_OFF, "R4");                            // R4 long low enable
        en = 1'b0; cycles(40);
        drained("R4");
        pix_half = 20; cycles(120);
        check_now(V_OFF, "R4");                       // R4 activity ignored while off

        lcm = 1'b1;                                   // R5 up through standby
        push(V_IDLE, "R5");
        push(V_ACQ, "R5");
        en = 1'b1; cycles(150);
        drained("R5");

        vs_pulse(); cycles(10);                       // R8 counted mode needs two
        check_now(V_ACQ, "R8");
        push(V_RUN, "R8");
        vs_pulse(); cycles(10);
        drained("R8");
        check_go(2, "R8");

        push(V_OFF, "R4");                            // R4 disable straight from transmit
        en = 1'b0; cycles(40);
        drained("R4");

        lcm = 1'b0;                                   // R9 clock loss in acquire
        lock = 1'b0;
        push(V_IDLE, "R9");
        push(V_ACQ, "R9");
        en = 1'b1; cycles(150);
        drained("R9");
        push(V_IDLE, "R9");
        pix_half = 0; cycles(120);
        drained("R9");
        check_go(2, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule